// File: doc/BRIEF.md
# Contactless Transmit Frame Serializer

This block converts a run of data bytes into the serial bit stream that a contactless reader's transmitter modulates onto the field. Bytes arrive on a valid/ready byte interface. Each byte is wrapped in a character frame and shifted out one bit for every pulse of an external bit-rate strobe. The frame can carry an optional leading start bit, eight data bits in either bit order, an optional parity bit, and a configurable tail of stop and guard-time bits.

Software, or a sequencer above the block, sets the framing options on static configuration pins and puts a byte count on `byte_count`. It then pulses `start`. The block samples the options and the count at that pulse and fetches one byte at a time, only when the previous frame has fully left the line. It flags the end of the transfer with a `done` pulse. A start with a zero count produces a `nodata_err` pulse and sends nothing. Line coding, CRC and the bit-rate generator belong to neighbouring blocks. The output here is plain NRZ.

Top module: `ctx_frame_serializer`

## Requirements
- R1: After reset and whenever no transfer is running, `ser_out` is 1, `busy` is 0, `in_ready` is 0, and `done` and `nodata_err` are 0.
- R2: With `cfg_start_bit` = 1, every frame begins with one bit at 0. With it at 0, the first data bit is the first bit of the frame.
- R3: With `cfg_msb_first` = 1, data bit 7 goes out first and bit 0 goes out last. With it at 0, bit 0 goes out first.
- R4: With `cfg_parity_en` = 1, one bit follows the eight data bits. With `cfg_parity_odd` = 0 it makes the count of ones across data and parity even. With `cfg_parity_odd` = 1 it makes that count odd.
- R5: With `cfg_last_par_inv` = 1 and parity enabled, only the final byte of the transfer has its parity bit inverted. Earlier bytes carry normal parity.
- R6: `cfg_stop_code` = n appends n bits at 1 after the data and parity. Code 0 appends nothing. Code 1 appends one stop bit. Codes 2 to 7 append one stop bit plus n-1 guard bits.
- R7: The block sends exactly one frame bit per cycle with `bit_en` high. `ser_out` changes only on the clock edge that ends a `bit_en` cycle. When the source keeps bytes available, frames follow one another with no gap.
- R8: A `start` pulse while idle with `byte_count` = 0 gives a one-cycle `nodata_err` on the next cycle. No byte is fetched, no bit is sent and no `done` pulse appears.
- R9: A byte is accepted (`in_valid` and `in_ready` both high) only once all bits of the previous frame, guard bits included, have had their full strobe period. Exactly `byte_count` bytes are accepted per transfer. If no byte is offered at that point, `ser_out` returns to 1 until one is.
- R10: `done` is a single one-cycle pulse per transfer. It appears after the clock edge of the strobe that ends the last bit period of the final frame, and `busy` falls at that same edge.
- R11: The framing options and the byte count are captured at the accepted `start`. Changing them during a transfer has no effect on that transfer.
- R12: A `start` pulse while `busy` is 1 is ignored. It neither restarts the transfer nor raises `nodata_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-rate strobe; one frame bit per high cycle |
| start | input | 1 | Begins a transfer when idle |
| byte_count | input | CNT_W | Number of bytes in the transfer |
| cfg_start_bit | input | 1 | Send a leading 0 bit per frame |
| cfg_msb_first | input | 1 | 1: bit 7 first; 0: bit 0 first |
| cfg_parity_en | input | 1 | Append a parity bit |
| cfg_parity_odd | input | 1 | 0: even parity; 1: odd parity |
| cfg_last_par_inv | input | 1 | Invert parity of the final byte |
| cfg_stop_code | input | 3 | Stop/guard tail length code |
| in_data | input | 8 | Byte offered by the source |
| in_valid | input | 1 | Source holds a byte |
| in_ready | output | 1 | Block accepts the byte this cycle |
| ser_out | output | 1 | Serial NRZ frame stream, idle high |
| busy | output | 1 | A transfer is running |
| done | output | 1 | One-cycle end-of-transfer pulse |
| nodata_err | output | 1 | One-cycle pulse: start with zero count |

## Verification
Most internal faults in this block surface as a wrong `ser_out` value at the very next strobe. Examples are a wrong bit index, a mis-sized frame, a parity slip or an early byte fetch. The bench therefore compares the line against a behavioural bit queue on every cycle. A byte counter that is off by one shows up at the end of the transfer: either a surplus handshake or a `done` pulse on the wrong strobe. The bench checks both the handshake count and the `done` pulse count per transfer. A stale or live configuration register gives wrong bits only when the inputs move during a transfer, so one run changes them mid-stream on purpose.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  localparam int BYTE_W    = 8;
  localparam int TAIL_MAX  = 7;                          // stop bit + 6 guard bits
  localparam int FRAME_W   = 1 + BYTE_W + 1 + TAIL_MAX;  // start + data + parity + tail
  localparam int LEN_W     = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SEND
  } ctx_state_e;

  typedef struct packed {
    logic       start_bit;
    logic       msb_first;
    logic       parity_en;
    logic       parity_odd;
    logic       last_par_inv;
    logic [2:0] stop_code;
  } ctx_cfg_t;

  // Parity bit: even parity is the XOR of the data, odd flips it, and the
  // final-byte inversion flips it once more.
  function automatic logic frame_parity(input logic [BYTE_W-1:0] d,
                                        input logic odd,
                                        input logic flip);
    return (^d) ^ odd ^ flip;
  endfunction

  // Number of trailing 1 bits for a stop/guard code: the code value itself.
  function automatic logic [LEN_W-1:0] tail_len(input logic [2:0] code);
    return LEN_W'(code);
  endfunction

  // Whole frame length in bits.
  function automatic logic [LEN_W-1:0] frame_len(input ctx_cfg_t c);
    return LEN_W'(c.start_bit) + LEN_W'(BYTE_W) + LEN_W'(c.parity_en)
         + tail_len(c.stop_code);
  endfunction

endpackage

// File: rtl/ctx_frame_builder.sv
module ctx_frame_builder
  import ctx_pkg::*;
(
  input  logic [BYTE_W-1:0]  data,
  input  ctx_cfg_t           cfg,
  input  logic               last,
  output logic [FRAME_W-1:0] f_bits,
  output logic [LEN_W-1:0]   f_len
);

  logic [BYTE_W-1:0]  ord;        // ord[0] is the first data bit on the line
  logic               par;
  logic [BYTE_W-1:0]  upper;      // parity and tail region above the data
  logic [FRAME_W-1:0] with_start;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_order
    assign ord[i] = cfg.msb_first ? data[BYTE_W-1-i] : data[i];
  end

  assign par = frame_parity(data, cfg.parity_odd, cfg.last_par_inv & last);

  // Bits above the data are all 1 except the parity slot when parity is on.
  assign upper = cfg.parity_en ? {{(BYTE_W-1){1'b1}}, par} : {BYTE_W{1'b1}};

  assign with_start = {upper, ord, 1'b0};

  // Without a start bit the frame slides down one place and fills with 1.
  assign f_bits = cfg.start_bit ? with_start : {1'b1, with_start[FRAME_W-1:1]};
  assign f_len  = frame_len(cfg);

endmodule

// File: rtl/ctx_byte_tracker.sv
module ctx_byte_tracker #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic [CNT_W-1:0] init_cnt,
  input  logic             take,
  output logic             last_one,
  output logic             none_left
);

  logic [CNT_W-1:0] remaining;   // bytes not yet fetched

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
    end else if (init) begin
      remaining <= init_cnt;
    end else if (take && remaining != '0) begin
      remaining <= remaining - CNT_W'(1);
    end
  end

  assign last_one  = (remaining == CNT_W'(1));
  assign none_left = (remaining == '0);

endmodule

// File: rtl/ctx_bit_sequencer.sv
module ctx_bit_sequencer
  import ctx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld,
  input  logic               ld_emit,
  input  logic               step,
  input  logic               hold_hi,
  input  logic [FRAME_W-1:0] f_bits,
  input  logic [LEN_W-1:0]   f_len,
  output logic               ser_out,
  output logic               frame_end
);

  logic [FRAME_W-1:0] frame_q;
  logic [LEN_W-1:0]   len_q;
  logic [LEN_W-1:0]   idx_q;     // bits already put on the line

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      len_q   <= '0;
      idx_q   <= '0;
      ser_out <= 1'b1;
    end else if (ld) begin
      frame_q <= f_bits;
      len_q   <= f_len;
      if (ld_emit) begin
        ser_out <= f_bits[0];
        idx_q   <= LEN_W'(1);
      end else begin
        idx_q   <= '0;
      end
    end else if (step) begin
      ser_out <= frame_q[idx_q];
      idx_q   <= idx_q + LEN_W'(1);
    end else if (hold_hi) begin
      ser_out <= 1'b1;
    end
  end

  assign frame_end = (idx_q == len_q);

endmodule

// File: rtl/ctx_frame_serializer.sv
module ctx_frame_serializer
  import ctx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             cfg_start_bit,
  input  logic             cfg_msb_first,
  input  logic             cfg_parity_en,
  input  logic             cfg_parity_odd,
  input  logic             cfg_last_par_inv,
  input  logic [2:0]       cfg_stop_code,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             ser_out,
  output logic             busy,
  output logic             done,
  output logic             nodata_err
);

  ctx_state_e st_q, st_d;
  ctx_cfg_t   cfg_in, cfg_q;

  // named internal events
  logic st_wait, st_send;
  logic start_go, start_empty;
  logic frame_end, at_boundary;
  logic hs, ld_emit, step, hold_hi, fin;
  logic last_one, none_left;

  logic [FRAME_W-1:0] f_bits;
  logic [LEN_W-1:0]   f_len;

  assign cfg_in = '{start_bit:    cfg_start_bit,
                    msb_first:    cfg_msb_first,
                    parity_en:    cfg_parity_en,
                    parity_odd:   cfg_parity_odd,
                    last_par_inv: cfg_last_par_inv,
                    stop_code:    cfg_stop_code};

  assign st_wait     = (st_q == ST_WAIT);
  assign st_send     = (st_q == ST_SEND);
  assign start_go    = (st_q == ST_IDLE) && start && (byte_count != '0);
  assign start_empty = (st_q == ST_IDLE) && start && (byte_count == '0);

  assign at_boundary = st_send && bit_en && frame_end;
  assign in_ready    = st_wait || (at_boundary && !none_left);
  assign hs          = in_ready && in_valid;
  assign ld_emit     = hs && st_send;
  assign step        = st_send && bit_en && !frame_end;
  assign hold_hi     = at_boundary && !hs;
  assign fin         = at_boundary && none_left;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_go) st_d = ST_WAIT;
      ST_WAIT: if (hs)       st_d = ST_SEND;
      ST_SEND: begin
        if (fin)                    st_d = ST_IDLE;
        else if (at_boundary && !hs) st_d = ST_WAIT;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cfg_q      <= '0;
      done       <= 1'b0;
      nodata_err <= 1'b0;
    end else begin
      st_q       <= st_d;
      done       <= fin;
      nodata_err <= start_empty;
      if (start_go) cfg_q <= cfg_in;
    end
  end

  assign busy = (st_q != ST_IDLE);

  ctx_byte_tracker #(.CNT_W(CNT_W)) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (start_go),
    .init_cnt  (byte_count),
    .take      (hs),
    .last_one  (last_one),
    .none_left (none_left)
  );

  ctx_frame_builder u_builder (
    .data   (in_data),
    .cfg    (cfg_q),
    .last   (last_one),
    .f_bits (f_bits),
    .f_len  (f_len)
  );

  ctx_bit_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld        (hs),
    .ld_emit   (ld_emit),
    .step      (step),
    .hold_hi   (hold_hi),
    .f_bits    (f_bits),
    .f_len     (f_len),
    .ser_out   (ser_out),
    .frame_end (frame_end)
  );

endmodule

// File: rtl/ctx_serializer_chk.sv
module ctx_serializer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             start,
  input logic [CNT_W-1:0] byte_count,
  input logic             in_valid,
  input logic             in_ready,
  input logic             ser_out,
  input logic             busy,
  input logic             done,
  input logic             nodata_err,
  input logic             st_wait,
  input logic             fin
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ser_out && !in_ready));

  assert_strobe_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> $stable(ser_out));

  assert_nodata_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && byte_count == '0) |=> (nodata_err && !busy && !done));

  assert_fetch_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid && !st_wait) |-> bit_en);

  assert_done_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bit_en) && ser_out && !busy && !nodata_err));

  assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !fin) |=> (busy && !nodata_err));

endmodule

bind ctx_frame_serializer ctx_serializer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .start      (start),
  .byte_count (byte_count),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .ser_out    (ser_out),
  .busy       (busy),
  .done       (done),
  .nodata_err (nodata_err),
  .st_wait    (st_wait),
  .fin        (fin)
);

// File: tb/test_ctx_frame_serializer.sv
`timescale 1ns/1ps
module test_ctx_frame_serializer;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, start = 1'b0;
  logic [CNT_W-1:0] byte_count = '0;
  logic c_sb = 0, c_msb = 0, c_pe = 0, c_po = 0, c_pi = 0;
  logic [2:0] c_code = 3'd0;
  logic [7:0] in_data = 8'h00;
  logic in_valid = 1'b0;
  logic in_ready, ser_out, busy, done, nodata_err;

  always #2.5 clk = ~clk;

  ctx_frame_serializer #(.CNT_W(CNT_W)) i_ctx_frame_serializer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start),
    .byte_count(byte_count), .cfg_start_bit(c_sb), .cfg_msb_first(c_msb),
    .cfg_parity_en(c_pe), .cfg_parity_odd(c_po), .cfg_last_par_inv(c_pi),
    .cfg_stop_code(c_code), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .ser_out(ser_out), .busy(busy), .done(done),
    .nodata_err(nodata_err));

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";
  bit run_cmp = 0;

  // reference model state
  bit   m_q[$];
  logic [7:0] src_q[$];
  bit   src_en = 1;
  bit   m_busy = 0;
  int   m_left = 0;
  bit   mc_sb, mc_msb, mc_pe, mc_po, mc_pi;
  int   mc_code;
  bit   exp_ser = 1, exp_done = 0, exp_err = 0;
  int   hs_cnt = 0, done_cnt = 0, err_cnt = 0;
  int   ph = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected frame, assembled bit by bit from the requirement text.
  task automatic push_frame(input logic [7:0] d, input bit last);
    bit p;
    if (mc_sb) m_q.push_back(1'b0);
    for (int k = 0; k < 8; k++) m_q.push_back(mc_msb ? d[7-k] : d[k]);
    if (mc_pe) begin
      p = ($countones(d) % 2) == 1;       // even: complete to an even count
      if (mc_po) p = !p;
      if (last && mc_pi) p = !p;
      m_q.push_back(p);
    end
    for (int k = 0; k < mc_code; k++) m_q.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_q.delete(); m_busy = 0; m_left = 0;
      exp_ser = 1; exp_done = 0; exp_err = 0;
    end else begin
      exp_done = 0; exp_err = 0;
      if (done) done_cnt++;
      if (nodata_err) err_cnt++;
      if (start && !m_busy) begin
        if (byte_count == 0) exp_err = 1;
        else begin
          m_busy = 1; m_left = int'(byte_count);
          mc_sb = c_sb; mc_msb = c_msb; mc_pe = c_pe; mc_po = c_po;
          mc_pi = c_pi; mc_code = int'(c_code);
        end
      end else if (m_busy) begin
        if (in_ready && in_valid) begin
          hs_cnt++;
          chk(m_q.size() == 0, "R9", "fetch before frame end, bits left",
              m_q.size(), 0);
          m_left--;
          push_frame(in_data, m_left == 0);
          if (src_q.size() > 0) void'(src_q.pop_front());
        end
        if (bit_en) begin
          if (m_q.size() > 0) exp_ser = m_q.pop_front();
          else begin
            exp_ser = 1;
            if (m_left <= 0) begin exp_done = 1; m_busy = 0; end
          end
        end
      end
    end
  end

  // compare away from the edge, then drive the strobe and the byte source
  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk(ser_out === exp_ser, cur_req, "ser_out", int'(ser_out), int'(exp_ser));
      chk(done === exp_done, "R10", "done", int'(done), int'(exp_done));
      chk(nodata_err === exp_err, "R8", "nodata_err", int'(nodata_err), int'(exp_err));
      chk(busy === m_busy, "R12", "busy", int'(busy), int'(m_busy));
    end
    ph = (ph + 1) % 4;
    bit_en = (ph == 3);
    in_valid = src_en && (src_q.size() > 0);
    in_data  = (src_q.size() > 0) ? src_q[0] : 8'h00;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic align(input int p);
    do @(posedge clk); while (ph != p);
  endtask

  // mode: 0 plain, 1 starve source, 2 move config mid-run, 3 extra start
  task automatic xfer(input bit sb, input bit msb, input bit pe, input bit po,
                      input bit pi, input logic [2:0] code, input int cnt,
                      input int mode, input string tag);
    cur_req = tag;
    for (int k = 0; k < cnt; k++) src_q.push_back(8'((k * 73 + cnt * 29 + 8'h5A) & 8'hFF));
    @(negedge clk);
    c_sb = sb; c_msb = msb; c_pe = pe; c_po = po; c_pi = pi; c_code = code;
    byte_count = CNT_W'(cnt);
    hs_cnt = 0; done_cnt = 0; err_cnt = 0;
    align(3);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (cnt == 0) begin
      repeat (4) @(negedge clk);
      chk(err_cnt == 1, "R8", "nodata pulses", err_cnt, 1);
      chk(done_cnt == 0, "R8", "done pulses", done_cnt, 0);
      chk(hs_cnt == 0, "R8", "bytes fetched", hs_cnt, 0);
      return;
    end
    repeat (20) @(negedge clk);
    if (mode == 1) begin
      src_en = 0;
      repeat (90) @(negedge clk);
      align(0);
      @(negedge clk); src_en = 1;
    end else if (mode == 2) begin
      c_sb = !sb; c_msb = !msb; c_pe = !pe; c_po = !po; c_pi = !pi;
      c_code = ~code; byte_count = CNT_W'(cnt + 3);
    end else if (mode == 3) begin
      byte_count = '0; start = 1;
      @(negedge clk); start = 0;
    end
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(hs_cnt == cnt, "R9", "bytes fetched", hs_cnt, cnt);
    chk(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
    if (mode == 3) chk(err_cnt == 0, "R12", "nodata on busy start", err_cnt, 0);
    chk(src_q.size() == 0, "R9", "bytes left in source", src_q.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ser_out === 1'b1, "R1", "idle ser_out", int'(ser_out), 1);
    chk(busy === 1'b0, "R1", "idle busy", int'(busy), 0);
    chk(in_ready === 1'b0, "R1", "idle in_ready", int'(in_ready), 0);
    chk(done === 1'b0 && nodata_err === 1'b0, "R1", "idle pulses",
        int'(done) + int'(nodata_err), 0);
    run_cmp = 1;

    xfer(0, 0, 0, 0, 0, 3'd0, 3, 0, "R2");   // no start bit, no tail
    xfer(1, 0, 0, 0, 0, 3'd1, 3, 0, "R2");   // start bit present
    xfer(1, 1, 0, 0, 0, 3'd1, 3, 0, "R3");   // MSB first
    xfer(0, 1, 0, 0, 0, 3'd0, 2, 0, "R3");
    xfer(1, 0, 1, 0, 0, 3'd1, 4, 0, "R4");   // even parity
    xfer(1, 1, 1, 1, 0, 3'd1, 4, 0, "R4");   // odd parity
    xfer(1, 0, 1, 0, 1, 3'd2, 3, 0, "R5");   // final parity inverted
    xfer(1, 0, 1, 1, 1, 3'd3, 1, 0, "R5");   // single byte is the final one
    for (int c = 0; c < 8; c++)
      xfer(1, c[1], 1, c[0], 0, 3'(c), 2, 0, "R6");
    xfer(0, 0, 0, 0, 0, 3'd0, 5, 0, "R7");   // back-to-back, no tail
    xfer(0, 0, 0, 0, 0, 3'd0, 0, 0, "R8");   // zero count
    xfer(1, 0, 1, 0, 0, 3'd4, 3, 1, "R9");   // source starves mid-run
    xfer(1, 1, 1, 0, 1, 3'd7, 2, 0, "R10");
    xfer(1, 0, 1, 0, 1, 3'd2, 3, 2, "R11");  // inputs moved mid-run
    xfer(0, 1, 1, 1, 0, 3'd5, 3, 3, "R12");  // start while busy

    repeat (10) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule